// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external controller read and write a small bank of 8-bit configuration registers over a serial link where the block is always the slave. A transaction starts when chip select goes low. The controller first sends a 16-bit instruction, most significant bit first. The instruction holds a read/write flag, a two-bit length code and a 13-bit register address. One or more data bytes follow, and the address steps up by one after every byte. Taking chip select high ends the transaction at any point.

The serial clock and select lines are brought into the block's own clock domain and sampled there. Input data is taken on the serial clock's rising edge. Read data is updated on its falling edge. The bidirectional data pad lives outside the block, so the block presents it as separate input, output and output-enable ports. In the default three-wire mode, read data goes out on the shared data line, and the block drives that line only during the data phase of a read. When bit 7 of register 0 is set, the block runs in four-wire mode: read data leaves on a separate output, and the shared line is used as an input only. All register contents are brought out in parallel for the rest of the chip.

Top module: `spireg_slave`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads 0x00 and both output enables are low.
- R2: The instruction is 16 bits, sent most significant bit first, in this order: read/write flag (1 = read), length bit 1, length bit 0, address bits 12 down to 0. In a write, each data byte is sent most significant bit first and is stored at the current address.
- R3: A length code of 00, 01 or 10 transfers 1, 2 or 3 data bytes. Any bytes clocked in after those are ignored.
- R4: A length code of 11 streams bytes until chip select rises. In every mode the address increments by one after each byte.
- R5: In a three-wire read, the block drives the shared data line only in the data phase. Bits leave most significant bit first, each one updated on a falling serial clock edge, and the dedicated output stays disabled.
- R6: When register 0 bit 7 is 1, read data appears on the dedicated output with its enable high, and the shared data line is never driven.
- R7: When chip select goes high, both output enables drop within SYNC_STAGES+3 clock cycles, and a partly received byte is not written.
- R8: Holding the serial clock still while chip select stays low pauses the transfer without aborting it.
- R9: Writes to addresses at or above NUM_REGS have no effect, and reads from those addresses return 0x00.
- R10: The shared-line enable and the dedicated-output enable are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the serial lines are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller, idle low |
| csb | input | 1 | Active-low chip select that frames a transaction |
| sdio_in | input | 1 | Value received from the shared data pad |
| sdio_out | output | 1 | Value to drive on the shared data pad |
| sdio_oe | output | 1 | Drive enable for the shared data pad |
| sdo_out | output | 1 | Value for the dedicated four-wire output pad |
| sdo_oe | output | 1 | Drive enable for the dedicated output pad |
| cfg_regs | output | NUM_REGS*8 | Register contents, register i in bits 8i+7 down to 8i |

## Verification
On every cycle, the assertions check four things. The two output enables are never high together. No enable is raised during the instruction phase. Both enables drop right after the synchronized select goes high. A register changes only after a sampled rising serial-clock edge inside a transaction. What only the bench scenarios can show: the bit order of instruction and data, how the length codes and streaming limit the byte count, address stepping, the handling of unimplemented addresses, a discarded partial byte, a clock stall, and the switch of read data onto the dedicated output.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
   localparam int INSTR_BITS = 16;
   localparam int ADDR_W     = 13;
   localparam logic [1:0] LEN_STREAM = 2'b11;

   typedef enum logic [1:0] {
      PH_INSTR = 2'd0,
      PH_DATA  = 2'd1,
      PH_DONE  = 2'd2
   } phase_e;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("spireg_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spireg_engine.sv
module spireg_engine
   import spireg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              din,
   input  logic [7:0]        rd_byte,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_byte,
   output logic              drive,
   output logic              dout,
   output phase_e            phase
);
   localparam int CNT_W = $clog2(INSTR_BITS) + 1;

   logic [INSTR_BITS-1:0] rx_sh;
   logic [CNT_W-1:0]      bit_cnt;
   logic                  rw;
   logic [1:0]            len;
   logic [1:0]            bytes_done;
   logic [7:0]            tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_INSTR;
         rx_sh      <= '0;
         bit_cnt    <= '0;
         rw         <= 1'b0;
         len        <= '0;
         bytes_done <= '0;
         addr       <= '0;
         tx_sh      <= '0;
         drive      <= 1'b0;
         dout       <= 1'b0;
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_byte    <= '0;
      end else if (cs_n) begin
         phase   <= PH_INSTR;
         bit_cnt <= '0;
         rx_sh   <= '0;
         drive   <= 1'b0;
         wr_en   <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (rise) begin
            rx_sh <= {rx_sh[INSTR_BITS-2:0], din};
            unique case (phase)
               PH_INSTR: begin
                  if (bit_cnt == CNT_W'(INSTR_BITS - 1)) begin
                     rw         <= rx_sh[INSTR_BITS-2];
                     len        <= rx_sh[INSTR_BITS-3:INSTR_BITS-4];
                     addr       <= {rx_sh[ADDR_W-2:0], din};
                     phase      <= PH_DATA;
                     bit_cnt    <= '0;
                     bytes_done <= '0;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               PH_DATA: begin
                  if (bit_cnt == CNT_W'(7)) begin
                     bit_cnt <= '0;
                     addr    <= addr + 1'b1;
                     if (!rw) begin
                        wr_en   <= 1'b1;
                        wr_addr <= addr;
                        wr_byte <= {rx_sh[6:0], din};
                     end
                     if (len != LEN_STREAM && bytes_done == len) begin
                        phase <= PH_DONE;
                        drive <= 1'b0;
                     end else begin
                        bytes_done <= bytes_done + 1'b1;
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end else if (fall && phase == PH_DATA && rw) begin
            drive <= 1'b1;
            if (bit_cnt == '0) begin
               dout  <= rd_byte[7];
               tx_sh <= {rd_byte[6:0], 1'b0};
            end else begin
               dout  <= tx_sh[7];
               tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
   import spireg_pkg::*;
#(
   parameter int NUM_REGS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [7:0]            wr_byte,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [7:0]            rd_byte,
   output logic [NUM_REGS*8-1:0] regs_flat
);
   logic [7:0] regs [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[i] <= 8'h00;
            else if (wr_en && wr_addr == ADDR_W'(i))
               regs[i] <= wr_byte;
         end
         assign regs_flat[i*8 +: 8] = regs[i];
      end
   endgenerate

   always_comb begin
      rd_byte = 8'h00;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_addr == ADDR_W'(i)) rd_byte = regs[i];
   end
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
   import spireg_pkg::*;
#(
   parameter int NUM_REGS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk,
   input  logic                  csb,
   input  logic                  sdio_in,
   output logic                  sdio_out,
   output logic                  sdio_oe,
   output logic                  sdo_out,
   output logic                  sdo_oe,
   output logic [NUM_REGS*8-1:0] cfg_regs
);
   localparam int MODE_BIT = 7;

   generate
      if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_regs
         $error("spireg_slave: NUM_REGS out of range 1..256");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spireg_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic sclk_s, csb_s, sdio_s, sclk_d;
   logic sclk_rise, sclk_fall;
   logic [ADDR_W-1:0] cur_addr, wr_addr;
   logic [7:0] rd_byte, wr_byte;
   logic wr_en, drive, dout, four_wire;
   phase_e phase_w;

   spireg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk
      (.clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   spireg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_csb
      (.clk(clk), .rst_n(rst_n), .d(csb), .q(csb_s));
   spireg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sdio
      (.clk(clk), .rst_n(rst_n), .d(sdio_in), .q(sdio_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;

   spireg_engine u_engine (
      .clk(clk), .rst_n(rst_n), .cs_n(csb_s), .rise(sclk_rise),
      .fall(sclk_fall), .din(sdio_s), .rd_byte(rd_byte), .addr(cur_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
      .drive(drive), .dout(dout), .phase(phase_w)
   );

   spireg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_byte(wr_byte), .rd_addr(cur_addr), .rd_byte(rd_byte),
      .regs_flat(cfg_regs)
   );

   assign four_wire = cfg_regs[MODE_BIT];
   assign sdio_out  = dout;
   assign sdo_out   = dout;
   assign sdio_oe   = drive & ~four_wire;
   assign sdo_oe    = drive & four_wire;
endmodule

// File: rtl/spireg_checker.sv
module spireg_checker
   import spireg_pkg::*;
#(
   parameter int NUM_REGS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  csb_s,
   input logic                  sclk_rise,
   input phase_e                phase,
   input logic                  sdio_oe,
   input logic                  sdo_oe,
   input logic [NUM_REGS*8-1:0] cfg_regs
);
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |-> (cfg_regs == '0 && !sdio_oe && !sdo_oe));

   p_oe_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdio_oe && sdo_oe));

   p_quiet_instr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_INSTR) |-> (!sdio_oe && !sdo_oe));

   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      csb_s |=> (!sdio_oe && !sdo_oe));

   p_write_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_regs) |-> $past(sclk_rise && !csb_s, 2));
endmodule

bind spireg_slave spireg_checker #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .csb_s(csb_s), .sclk_rise(sclk_rise),
   .phase(phase_w), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe), .cfg_regs(cfg_regs)
);

// File: tb/sim_spireg_slave.sv
module sim_spireg_slave;
   localparam int NREG = 8;
   localparam time H   = 80ns;

   logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csb = 1'b1, m_sdio = 1'b0;
   logic sdio_out, sdio_oe, sdo_out, sdo_oe;
   logic [NREG*8-1:0] cfg_regs;

   int n_chk = 0, n_bad = 0;

   logic [7:0] wbuf [0:7];
   logic [7:0] rx3  [0:7];
   logic [7:0] rx4  [0:7];
   logic oe3_byte [0:7];
   logic oe4_byte [0:7];
   logic instr_oe, oe_after_csb;

   always #5ns clk = ~clk;

   spireg_slave #(.NUM_REGS(NREG), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(m_sdio),
      .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out),
      .sdo_oe(sdo_oe), .cfg_regs(cfg_regs)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] reg_at(input int i);
      return cfg_regs[i*8 +: 8];
   endfunction

   task automatic clk_bit(input logic b, output logic s3, output logic e3,
                          output logic s4, output logic e4);
      m_sdio = b;
      #(H);
      s3 = sdio_out; e3 = sdio_oe; s4 = sdo_out; e4 = sdo_oe;
      sclk = 1'b1;
      #(H);
      sclk = 1'b0;
   endtask

   task automatic xfer(input logic rw, input logic [1:0] len, input logic [12:0] addr,
                       input int nbytes, input int extra_bits, input int stall_bit);
      logic [15:0] ins;
      logic s3, e3, s4, e4;
      int bitno;
      ins = {rw, len, addr};
      instr_oe = 1'b0;
      bitno = 0;
      for (int b = 0; b < 8; b++) begin
         rx3[b] = '0; rx4[b] = '0; oe3_byte[b] = 1'b0; oe4_byte[b] = 1'b0;
      end
      csb = 1'b0;
      #(H);
      for (int i = 15; i >= 0; i--) begin
         clk_bit(ins[i], s3, e3, s4, e4);
         instr_oe = instr_oe | e3 | e4;
         bitno++;
      end
      for (int b = 0; b < nbytes; b++) begin
         for (int k = 7; k >= 0; k--) begin
            if (bitno == stall_bit) #(H * 40);
            clk_bit(wbuf[b][k], s3, e3, s4, e4);
            rx3[b][k] = s3; rx4[b][k] = s4;
            oe3_byte[b] = oe3_byte[b] | e3;
            oe4_byte[b] = oe4_byte[b] | e4;
            bitno++;
         end
      end
      for (int x = 0; x < extra_bits; x++) clk_bit(1'b1, s3, e3, s4, e4);
      #(H);
      csb = 1'b1;
      #50ns;
      oe_after_csb = sdio_oe | sdo_oe;
      #(H * 2);
   endtask

   // Vector table: {rw, len, addr, data/expected}
   localparam int NVEC = 7;
   localparam logic [23:0] VEC [0:NVEC-1] = '{
      {1'b0, 2'b00, 13'h0001, 8'hA5},
      {1'b1, 2'b00, 13'h0001, 8'hA5},
      {1'b0, 2'b00, 13'h0007, 8'h3C},
      {1'b1, 2'b00, 13'h0007, 8'h3C},
      {1'b0, 2'b00, 13'h0100, 8'hFF},
      {1'b1, 2'b00, 13'h0100, 8'h00},
      {1'b1, 2'b00, 13'h0008, 8'h00}
   };

   initial begin : watchdog
      #1ms;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: state while reset held
      chk("R1 regs in reset", cfg_regs, '0);
      chk("R1 oe in reset", {sdio_oe, sdo_oe}, 2'b00);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 regs after reset", cfg_regs, '0);
      chk("R1 oe after reset", {sdio_oe, sdo_oe}, 2'b00);

      // Table walk: single-byte writes and reads (R2, R5, R9)
      for (int v = 0; v < NVEC; v++) begin
         logic [23:0] e;
         e = VEC[v];
         wbuf[0] = e[7:0];
         xfer(e[23], e[22:21], e[20:8], 1, 0, -1);
         if (!e[23]) begin
            if (e[20:8] < 13'(NREG))
               chk("R2 write stored", reg_at(int'(e[20:8])), e[7:0]);
            else
               chk("R9 unimplemented write ignored", cfg_regs,
                   {8'h3C, 40'h0, 8'hA5, 8'h00});
         end else begin
            chk(e[20:8] < 13'(NREG) ? "R5 read data" : "R9 unimplemented read zero",
                rx3[0], e[7:0]);
            chk("R5 sdio driven in data only", {instr_oe, oe3_byte[0], oe4_byte[0]}, 3'b010);
         end
      end

      // R3: length 01 gives two bytes; third byte ignored
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      xfer(1'b0, 2'b01, 13'h0002, 3, 0, -1);
      chk("R3 len01 bytes", {reg_at(2), reg_at(3), reg_at(4)}, 24'h112200);

      // R3: length 10 gives three bytes; fourth ignored (reg7 keeps 3C)
      wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66; wbuf[3] = 8'h77;
      xfer(1'b0, 2'b10, 13'h0004, 4, 0, -1);
      chk("R3 len10 bytes", {reg_at(4), reg_at(5), reg_at(6), reg_at(7)}, 32'h4455663C);

      // R4 streaming with R8 stall in the middle of the second byte
      wbuf[0] = 8'h0A; wbuf[1] = 8'h0B; wbuf[2] = 8'h0C; wbuf[3] = 8'h0D;
      xfer(1'b0, 2'b11, 13'h0002, 4, 0, 28);
      chk("R4 R8 stream write with stall", {reg_at(2), reg_at(3), reg_at(4), reg_at(5)},
          32'h0A0B0C0D);

      // R5 multi-byte three-wire read with auto-increment
      xfer(1'b1, 2'b10, 13'h0002, 3, 0, -1);
      chk("R5 R4 read bytes", {rx3[0], rx3[1], rx3[2]}, 24'h0A0B0C);
      chk("R5 oe phases", {instr_oe, oe3_byte[0], oe3_byte[2], oe4_byte[1]}, 4'b0110);

      // R3: read of length 00 releases the line for an extra byte
      xfer(1'b1, 2'b00, 13'h0001, 2, 0, -1);
      chk("R3 read stops after one byte", {rx3[0], oe3_byte[0], oe3_byte[1]},
          {8'hA5, 1'b1, 1'b0});

      // R7: partial byte discarded
      xfer(1'b0, 2'b00, 13'h0001, 0, 5, -1);
      chk("R7 partial byte not written", reg_at(1), 8'hA5);

      // R7: abort a streaming read mid-byte, enables drop quickly
      wbuf[0] = 8'h00;
      xfer(1'b1, 2'b11, 13'h0004, 1, 3, -1);
      chk("R7 oe released after csb", oe_after_csb, 1'b0);
      chk("R4 stream read first byte", rx3[0], 8'h0C);

      // R6: four-wire mode
      wbuf[0] = 8'h80;
      xfer(1'b0, 2'b00, 13'h0000, 1, 0, -1);
      chk("R6 mode bit set", reg_at(0), 8'h80);
      xfer(1'b1, 2'b01, 13'h0005, 2, 0, -1);
      chk("R6 data on dedicated output", {rx4[0], rx4[1]}, 16'h0D66);
      chk("R6 R10 enables", {oe3_byte[0], oe3_byte[1], oe4_byte[0], oe4_byte[1], instr_oe},
          5'b00110);
      wbuf[0] = 8'h00;
      xfer(1'b0, 2'b00, 13'h0000, 1, 0, -1);
      chk("R6 back to three-wire", reg_at(0), 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule